// File: doc/BRIEF.md
# Overlay Window Fetch Address Generator

This block serves one overlay window of a display controller. It watches the raster position coming from the timing generator and raises an in-window flag for every pixel that falls inside the window's on-screen rectangle. For each raster line that crosses the window it also produces the frame-buffer byte addresses to read, one 32-bit word at a time. A downstream bus master takes these addresses through a valid/ready handshake.

The address walk handles a window that shows only part of a wider frame buffer. Within a line it reads a programmed number of bytes (the line span). It then moves on by a separate gap byte count, so that the next line starts one buffer pitch after the previous one. A stop address ends fetching for the rest of the frame. All window settings pass through a shadow stage. They are taken up only at a frame-start strobe, and only while the lock input is low, so software can rewrite several fields without the display seeing a half-updated set.

Handshake rules: when `fetch_valid` is high and `fetch_ready` is low, the address is held steady and valid stays high until the word is accepted. A `line_start` or `frame_start` strobe drops any words not yet accepted on the current line. `fetch_ready` may change freely while `fetch_valid` is low.

Top module: `ovl_fetch_addr_gen`

## Requirements
- R1: `in_window` is high one clock after a position (`pix_x`, `pix_y`) with left <= x <= right and top <= y <= bottom, where the corner values are inclusive and come from the active shadow settings with the window enabled. Otherwise `in_window` is low one clock later.
- R2: While the active enable is low, `in_window` stays low and `fetch_valid` stays low.
- R3: A `line_start` with `pix_y` inside [top, bottom] opens a line. That line issues exactly span/4 word addresses, rising by 4 from the line's start address.
- R4: The first window line after a `frame_start` begins at the start address. Each later window line begins span + gap bytes after the previous line's start.
- R5: No address equal to or above the stop address is ever issued.
- R6: Settings presented on the `cfg_*` pins become active only on a clock where `frame_start` is high and `cfg_lock` is low. With `cfg_lock` high the previous settings stay in force.
- R7: Every `frame_start` restarts the address walk, so the next frame's first window line begins again at the start address.
- R8: `cfg_error` is high while the active span or gap has either of its two low bits set. While it is high, no fetch is issued.
- R9: When `fetch_valid` is high and `fetch_ready` is low (and no strobe arrives), the next clock still shows `fetch_valid` high with the same `fetch_addr`.
- R10: After reset, `in_window`, `fetch_valid` and `cfg_error` are low and the window is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_x | input | 12 | Raster column |
| pix_y | input | 12 | Raster row |
| line_start | input | 1 | One-clock strobe at the start of each raster line |
| frame_start | input | 1 | One-clock strobe at vertical sync |
| cfg_enable | input | 1 | Window enable (shadowed) |
| cfg_lock | input | 1 | Blocks shadow update while high |
| cfg_start | input | 32 | Byte address of the first fetched word (shadowed) |
| cfg_stop | input | 32 | First byte address not to fetch (shadowed) |
| cfg_span | input | 16 | Bytes read per window line (shadowed) |
| cfg_gap | input | 16 | Bytes skipped after each line (shadowed) |
| cfg_left | input | 12 | Leftmost window column, inclusive (shadowed) |
| cfg_top | input | 12 | Topmost window row, inclusive (shadowed) |
| cfg_right | input | 12 | Rightmost window column, inclusive (shadowed) |
| cfg_bottom | input | 12 | Bottom window row, inclusive (shadowed) |
| in_window | output | 1 | Registered hit flag for the position one clock earlier |
| fetch_valid | output | 1 | A fetch address is offered |
| fetch_ready | input | 1 | Downstream accepts the offered address |
| fetch_addr | output | 32 | Byte address of the word to read |
| cfg_error | output | 1 | Span or gap not word aligned |

## Verification
A wrong line base or word offset shows at the ports on the first accepted word of the affected line, as an address out of step with the buffer pitch. A missed shadow load shows one frame late, through both the hit flag and the first address of the next window line. A stall that loses or repeats a word shows as a gap or a duplicate in the captured address list of that same line. A stop-address or alignment fault shows as words issued where none are due, within the line that opens after the bad settings take effect.

// File: rtl/ofa_pkg.sv
package ofa_pkg;
  parameter int unsigned ADDR_W     = 32;
  parameter int unsigned COORD_W    = 12;
  parameter int unsigned SPAN_W     = 16;
  parameter int unsigned WORD_BYTES = 4;
  localparam int unsigned WORD_LSB  = $clog2(WORD_BYTES);

  typedef struct packed {
    logic               enable;
    logic [ADDR_W-1:0]  start;
    logic [ADDR_W-1:0]  stop;
    logic [SPAN_W-1:0]  span;
    logic [SPAN_W-1:0]  gap;
    logic [COORD_W-1:0] left;
    logic [COORD_W-1:0] top;
    logic [COORD_W-1:0] right;
    logic [COORD_W-1:0] bottom;
  } win_cfg_t;
endpackage

// File: rtl/ofa_shadow.sv
module ofa_shadow
  import ofa_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     frame_start,
  input  logic     lock,
  input  win_cfg_t staged,
  output win_cfg_t active,
  output logic     align_err
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= '0;
    end else if (frame_start && !lock) begin
      active <= staged;
    end
  end

  always_comb begin
    align_err = (|active.span[WORD_LSB-1:0]) | (|active.gap[WORD_LSB-1:0]);
  end

  // R6
  locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_start || lock) |=> $stable(active));
endmodule

// File: rtl/ofa_region.sv
module ofa_region
  import ofa_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  win_cfg_t           act,
  input  logic [COORD_W-1:0] pix_x,
  input  logic [COORD_W-1:0] pix_y,
  output logic               row_hit,
  output logic               in_window
);
  logic col_hit;

  always_comb begin
    row_hit = act.enable && (pix_y >= act.top) && (pix_y <= act.bottom);
    col_hit = (pix_x >= act.left) && (pix_x <= act.right);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_window <= 1'b0;
    end else begin
      in_window <= row_hit && col_hit;
    end
  end

  // R2
  off_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !act.enable |=> !in_window);
endmodule

// File: rtl/ofa_addr_walk.sv
module ofa_addr_walk
  import ofa_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  win_cfg_t          act,
  input  logic              align_err,
  input  logic              row_hit,
  input  logic              line_start,
  input  logic              frame_start,
  input  logic              fetch_ready,
  output logic              fetch_valid,
  output logic [ADDR_W-1:0] fetch_addr
);
  localparam logic [SPAN_W-1:0] STEP = SPAN_W'(WORD_BYTES);
  localparam int unsigned       PADW = ADDR_W - SPAN_W;

  logic              line_open;
  logic              first_line;
  logic [ADDR_W-1:0] line_base;
  logic [SPAN_W-1:0] word_off;
  logic [ADDR_W-1:0] pitch;
  logic              take;

  always_comb begin
    pitch       = {{PADW{1'b0}}, act.span} + {{PADW{1'b0}}, act.gap};
    fetch_addr  = line_base + {{PADW{1'b0}}, word_off};
    fetch_valid = line_open && act.enable && !align_err &&
                  (word_off < act.span) && (fetch_addr < act.stop);
    take        = fetch_valid && fetch_ready;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_open  <= 1'b0;
      first_line <= 1'b1;
      line_base  <= '0;
      word_off   <= '0;
    end else if (frame_start) begin
      line_open  <= 1'b0;
      first_line <= 1'b1;
      word_off   <= '0;
    end else if (line_start) begin
      word_off <= '0;
      if (row_hit) begin
        line_open  <= 1'b1;
        first_line <= 1'b0;
        line_base  <= first_line ? act.start : (line_base + pitch);
      end else begin
        line_open <= 1'b0;
      end
    end else if (take) begin
      word_off <= word_off + STEP;
    end
  end

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !fetch_ready && !line_start && !frame_start)
      |=> (fetch_valid && $stable(fetch_addr)));

  // R3
  word_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !line_start && !frame_start)
      |=> (!fetch_valid || (fetch_addr == $past(fetch_addr) + ADDR_W'(WORD_BYTES))));
endmodule

// File: rtl/ovl_fetch_addr_gen.sv
module ovl_fetch_addr_gen
  import ofa_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [COORD_W-1:0] pix_x,
  input  logic [COORD_W-1:0] pix_y,
  input  logic               line_start,
  input  logic               frame_start,
  input  logic               cfg_enable,
  input  logic               cfg_lock,
  input  logic [ADDR_W-1:0]  cfg_start,
  input  logic [ADDR_W-1:0]  cfg_stop,
  input  logic [SPAN_W-1:0]  cfg_span,
  input  logic [SPAN_W-1:0]  cfg_gap,
  input  logic [COORD_W-1:0] cfg_left,
  input  logic [COORD_W-1:0] cfg_top,
  input  logic [COORD_W-1:0] cfg_right,
  input  logic [COORD_W-1:0] cfg_bottom,
  output logic               in_window,
  output logic               fetch_valid,
  input  logic               fetch_ready,
  output logic [ADDR_W-1:0]  fetch_addr,
  output logic               cfg_error
);
  win_cfg_t staged;
  win_cfg_t act;
  logic     row_hit;

  always_comb begin
    staged.enable = cfg_enable;
    staged.start  = cfg_start;
    staged.stop   = cfg_stop;
    staged.span   = cfg_span;
    staged.gap    = cfg_gap;
    staged.left   = cfg_left;
    staged.top    = cfg_top;
    staged.right  = cfg_right;
    staged.bottom = cfg_bottom;
  end

  ofa_shadow u_shadow (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .lock        (cfg_lock),
    .staged      (staged),
    .active      (act),
    .align_err   (cfg_error)
  );

  ofa_region u_region (
    .clk       (clk),
    .rst_n     (rst_n),
    .act       (act),
    .pix_x     (pix_x),
    .pix_y     (pix_y),
    .row_hit   (row_hit),
    .in_window (in_window)
  );

  ofa_addr_walk u_walk (
    .clk         (clk),
    .rst_n       (rst_n),
    .act         (act),
    .align_err   (cfg_error),
    .row_hit     (row_hit),
    .line_start  (line_start),
    .frame_start (frame_start),
    .fetch_ready (fetch_ready),
    .fetch_valid (fetch_valid),
    .fetch_addr  (fetch_addr)
  );

  // R2
  dis_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !act.enable |-> !fetch_valid);

  // R5
  stop_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |-> (fetch_addr < act.stop));

  // R8
  align_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_error |-> !fetch_valid);
endmodule

// File: tb/tb_ovl_fetch_addr_gen.sv
module tb_ovl_fetch_addr_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] pix_x = '0, pix_y = '0;
  logic        line_start = 1'b0, frame_start = 1'b0;
  logic        cfg_enable = 1'b0, cfg_lock = 1'b0;
  logic [31:0] cfg_start = '0, cfg_stop = '0;
  logic [15:0] cfg_span = '0, cfg_gap = '0;
  logic [11:0] cfg_left = '0, cfg_top = '0, cfg_right = '0, cfg_bottom = '0;
  logic        in_window, fetch_valid, cfg_error;
  logic        fetch_ready = 1'b0;
  logic [31:0] fetch_addr;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  logic        cap_on = 1'b0;
  logic [31:0] cap [32];
  int          cap_n = 0;

  always #10 clk = ~clk;

  ovl_fetch_addr_gen dut (
    .clk(clk), .rst_n(rst_n), .pix_x(pix_x), .pix_y(pix_y),
    .line_start(line_start), .frame_start(frame_start),
    .cfg_enable(cfg_enable), .cfg_lock(cfg_lock),
    .cfg_start(cfg_start), .cfg_stop(cfg_stop),
    .cfg_span(cfg_span), .cfg_gap(cfg_gap),
    .cfg_left(cfg_left), .cfg_top(cfg_top),
    .cfg_right(cfg_right), .cfg_bottom(cfg_bottom),
    .in_window(in_window), .fetch_valid(fetch_valid),
    .fetch_ready(fetch_ready), .fetch_addr(fetch_addr),
    .cfg_error(cfg_error)
  );

  always @(negedge clk) begin
    if (cap_on && fetch_valid && fetch_ready && cap_n < 32) begin
      cap[cap_n] <= fetch_addr;
      cap_n <= cap_n + 1;
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: run did not finish act=%0d exp=%0d", cycles, 20000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // x, y, expected hit for window columns 10..20, rows 2..4
  localparam logic [24:0] VEC [10] = '{
    {12'd10, 12'd2, 1'b1}, {12'd9,  12'd2, 1'b0},
    {12'd20, 12'd4, 1'b1}, {12'd21, 12'd4, 1'b0},
    {12'd15, 12'd1, 1'b0}, {12'd15, 12'd5, 1'b0},
    {12'd15, 12'd3, 1'b1}, {12'd10, 12'd4, 1'b1},
    {12'd20, 12'd2, 1'b1}, {12'd0,  12'd0, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic new_frame();
    frame_start = 1'b1; tick(); frame_start = 1'b0; tick();
  endtask

  task automatic run_line(input int y);
    pix_y = 12'(y); line_start = 1'b1; tick(); line_start = 1'b0;
    repeat (7) tick();
  endtask

  task automatic hit_at(input int x, input int y, input bit exp, input string req);
    pix_x = 12'(x); pix_y = 12'(y);
    @(posedge clk); @(negedge clk);
    chk(in_window == exp, req, {31'd0, in_window}, {31'd0, exp});
    tick();
  endtask

  task automatic base_cfg();
    cfg_enable = 1'b1; cfg_start = 32'h1000; cfg_stop = 32'h10000;
    cfg_span = 16'd16; cfg_gap = 16'd8;
    cfg_left = 12'd10; cfg_top = 12'd2; cfg_right = 12'd20; cfg_bottom = 12'd4;
  endtask

  initial begin
    repeat (3) tick();
    @(negedge clk);
    // R10 reset state
    chk(!in_window, "R10 in_window", {31'd0, in_window}, 0);
    chk(!fetch_valid, "R10 fetch_valid", {31'd0, fetch_valid}, 0);
    chk(!cfg_error, "R10 cfg_error", {31'd0, cfg_error}, 0);
    tick();
    rst_n = 1'b1;
    tick();

    base_cfg();
    new_frame();
    // R1 table walk
    for (int i = 0; i < 10; i++) begin
      hit_at(int'(VEC[i][24:13]), int'(VEC[i][12:1]), VEC[i][0], "R1 hit");
    end

    // R3 R4 address walk with nonzero gap
    new_frame();
    fetch_ready = 1'b1; cap_n = 0; cap_on = 1'b1;
    for (int y = 0; y < 6; y++) run_line(y);
    cap_on = 1'b0;
    chk(cap_n == 12, "R3 word count", 32'(cap_n), 12);
    for (int r = 0; r < 3; r++) begin
      for (int w = 0; w < 4; w++) begin
        chk(cap[r*4+w] == 32'h1000 + 32'(r*24 + w*4), "R4 address",
            cap[r*4+w], 32'h1000 + 32'(r*24 + w*4));
      end
    end

    // R7 restart at frame start
    new_frame();
    cap_n = 0; cap_on = 1'b1;
    run_line(2);
    cap_on = 1'b0;
    chk(cap_n == 4 && cap[0] == 32'h1000, "R7 restart", cap[0], 32'h1000);

    // R5 stop address
    cfg_stop = 32'h1020;
    new_frame();
    cap_n = 0; cap_on = 1'b1;
    run_line(2); run_line(3); run_line(4);
    cap_on = 1'b0;
    chk(cap_n == 6, "R5 count", 32'(cap_n), 6);
    chk(cap[5] == 32'h101C, "R5 last", cap[5], 32'h101C);

    // R9 back-pressure
    fetch_ready = 1'b0;
    new_frame();
    pix_y = 12'd2; line_start = 1'b1; tick(); line_start = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(fetch_valid && fetch_addr == 32'h1000, "R9 hold", fetch_addr, 32'h1000);
      tick();
    end
    cap_n = 0; cap_on = 1'b1; fetch_ready = 1'b1;
    repeat (8) tick();
    cap_on = 1'b0;
    chk(cap_n == 4 && cap[0] == 32'h1000 && cap[3] == 32'h100C, "R9 resume", cap[3], 32'h100C);

    // R6 lock holds old settings
    cfg_lock = 1'b1;
    cfg_left = 12'd100; cfg_right = 12'd120; cfg_start = 32'h2000; cfg_stop = 32'h10000;
    new_frame();
    hit_at(15, 3, 1'b1, "R6 locked hit");
    cap_n = 0; cap_on = 1'b1; run_line(2); cap_on = 1'b0;
    chk(cap[0] == 32'h1000, "R6 locked addr", cap[0], 32'h1000);
    cfg_lock = 1'b0;
    new_frame();
    hit_at(15, 3, 1'b0, "R6 new miss");
    hit_at(100, 3, 1'b1, "R6 new hit");
    cap_n = 0; cap_on = 1'b1; run_line(2); cap_on = 1'b0;
    chk(cap[0] == 32'h2000, "R6 new addr", cap[0], 32'h2000);

    // R8 misaligned span
    cfg_span = 16'd14;
    new_frame();
    @(negedge clk);
    chk(cfg_error, "R8 flag", {31'd0, cfg_error}, 1);
    tick();
    cap_n = 0; cap_on = 1'b1; run_line(2); cap_on = 1'b0;
    chk(cap_n == 0, "R8 no fetch", 32'(cap_n), 0);

    // R2 disabled window
    cfg_span = 16'd16; cfg_enable = 1'b0;
    new_frame();
    hit_at(105, 3, 1'b0, "R2 no hit");
    cap_n = 0; cap_on = 1'b1; run_line(2); cap_on = 1'b0;
    chk(cap_n == 0, "R2 no fetch", 32'(cap_n), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule